// File: doc/BRIEF.md
# I2C Controller Register Front End

This block is the register face of a byte-oriented I2C controller. Software reaches it over a simple synchronous register bus: an address, a write strobe, write data, and combinational read data. It holds four control flags: acknowledge enable, interrupt flag, start request and interface enable. Software raises these flags through a set address and drops them through a separate clear address. In both cases only the bits written as one act. The protocol engine itself is not part of this block. It appears here only as a 5-bit state code and a strobe that marks entry into a new state.

The block latches each accepted state code into a read-only status byte. When the engine enters any state other than idle, the block raises the interrupt flag. The interrupt output is the interrupt flag gated by the interface enable. When software drops the enable, the next cycle returns the block to its idle picture: the status reads idle, and the interrupt flag and start request are cleared.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: After reset, all control flags are 0, the status byte at offset 0x04 reads 0xF8, and `irq` is 0.
- R2: Writing offset 0x00 sets each flag whose bit is 1 and leaves flags written as 0 unchanged. The bit positions are: acknowledge enable bit 2, interrupt flag bit 3, start request bit 5, interface enable bit 6. Reading offset 0x00 returns the flags at those positions.
- R3: Writing offset 0x18 clears each flag whose bit (same positions as R2) is 1 and leaves flags written as 0 unchanged.
- R4: Bits 1:0, 4 and 7 of a write to 0x00 or 0x18 have no effect, and those bits read as 0 at offset 0x00.
- R5: The status byte has bits 2:0 always 0 and bits 7:3 equal to the code of the last state entry accepted while the interface was enabled. Entries arriving while disabled are ignored.
- R6: An accepted entry with a code other than 0x1F sets the interrupt flag at the same clock edge that loads the status. An entry with code 0x1F updates the status but does not set the flag.
- R7: When an accepted non-idle entry and a clear-register write of bit 3 fall in the same cycle, the interrupt flag ends up set.
- R8: A clear-register write of bit 6 while the interface is enabled drops the enable at that edge. At the following edge it forces the status back to 0xF8 and clears the interrupt flag and start request. Acknowledge enable is left unchanged.
- R9: `irq` is 1 exactly when both the interrupt flag and the interface enable are 1.
- R10: Writes to offsets other than 0x00 and 0x18 change nothing, and every offset other than 0x00 and 0x04 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| eng_code | input | 5 | State code from the protocol engine |
| eng_enter | input | 1 | Engine entered the state on `eng_code` |
| ctl_aa | output | 1 | Acknowledge enable flag to the engine |
| ctl_sta | output | 1 | Start request flag to the engine |
| ctl_en | output | 1 | Interface enable flag to the engine |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flag or status code becomes visible at the ports one edge after the offending write or state entry. It shows on `bus_rdata` at 0x00 or 0x04, on the three control outputs, and on `irq`. The only exception is the idle return: it lands two edges after the enable is cleared, and the bench samples both the intermediate and the final picture. Same-cycle conflicts between a clear write and a state entry are driven deliberately, because a wrong priority leaves the interrupt flag low and loses an event.

// File: rtl/i2c_regs_pkg.sv
// Shared constants and helpers for the I2C register front end.
// Assumes an 8-bit register bus and a 5-bit engine state code.
package i2c_regs_pkg;
    localparam int DATA_W  = 8;
    localparam int CODE_W  = 5;
    localparam int NFLAG   = 4;
    // Flag index -> bit position in the control byte (index order: aa, si, sta, en)
    localparam int FLAG_AA  = 0;
    localparam int FLAG_SI  = 1;
    localparam int FLAG_STA = 2;
    localparam int FLAG_EN  = 3;
    localparam logic [CODE_W-1:0] IDLE_CODE = '1;

    // Returns the control-byte bit position of flag index i
    function automatic int flag_pos(input int i);
        case (i)
            FLAG_AA:  flag_pos = 2;
            FLAG_SI:  flag_pos = 3;
            FLAG_STA: flag_pos = 5;
            default:  flag_pos = 6;
        endcase
    endfunction

    // Places the flag vector at its byte positions, reserved bits zero
    function automatic logic [DATA_W-1:0] pack_flags(input logic [NFLAG-1:0] f);
        logic [DATA_W-1:0] b;
        b = '0;
        for (int i = 0; i < NFLAG; i++) b[flag_pos(i)] = f[i];
        return b;
    endfunction
endpackage

// File: rtl/i2c_flag_bank.sv
// Control flag bank: write-one-to-set and write-one-to-clear per flag.
// The interrupt flag also takes an engine set request, which wins over a
// clear. A force-idle pulse clears the interrupt and start flags and
// overrides every other source. Assumes set and clear never share a cycle.
module i2c_flag_bank
    import i2c_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_si_set,
    input  logic              force_idle,
    output logic [NFLAG-1:0]  flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam int  POS     = flag_pos(i);
        localparam bit  HW_SET  = (i == FLAG_SI);
        localparam bit  FORCED  = (i == FLAG_SI) || (i == FLAG_STA);
        logic hw_set;
        logic forced;
        assign hw_set = HW_SET ? hw_si_set  : 1'b0;
        assign forced = FORCED ? force_idle : 1'b0;

        // Updates one flag by priority: force, engine set, clear, set
        always_ff @(posedge clk) begin
            if (!rst_n)                    flags[i] <= 1'b0;
            else if (forced)               flags[i] <= 1'b0;
            else if (hw_set)               flags[i] <= 1'b1;
            else if (clr_we && wdata[POS]) flags[i] <= 1'b0;
            else if (set_we && wdata[POS]) flags[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_status_track.sv
// Status tracker: latches accepted engine state codes, requests the
// interrupt flag on non-idle entries, and produces the one-cycle
// force-idle pulse that follows an interface disable.
// Assumes en_q is the registered interface enable flag.
module i2c_status_track
    import i2c_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              eng_enter,
    input  logic [CODE_W-1:0] eng_code,
    input  logic              disable_req,
    output logic [CODE_W-1:0] code_q,
    output logic              hw_si_set,
    output logic              force_idle
);
    logic accept;
    assign accept    = eng_enter && en_q;
    assign hw_si_set = accept && (eng_code != IDLE_CODE);

    // Arms the idle return one cycle after an enabled interface is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) force_idle <= 1'b0;
        else        force_idle <= disable_req && en_q;
    end

    // Holds the status code: reset and idle return load idle, else accepted code
    always_ff @(posedge clk) begin
        if (!rst_n)          code_q <= IDLE_CODE;
        else if (force_idle) code_q <= IDLE_CODE;
        else if (accept)     code_q <= eng_code;
    end
endmodule

// File: rtl/i2c_read_mux.sv
// Read data selection by offset. Unmapped offsets, including the clear
// register, read zero. Purely combinational.
module i2c_read_mux
    import i2c_regs_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int OFF_SET  = 'h00,
    parameter int OFF_STAT = 'h04
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NFLAG-1:0]  flags,
    input  logic [CODE_W-1:0] code_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - CODE_W;

    // Selects the register image addressed by the bus
    always_comb begin
        if (addr == ADDR_W'(OFF_SET))       rdata = pack_flags(flags);
        else if (addr == ADDR_W'(OFF_STAT)) rdata = {code_q, {PAD_W{1'b0}}};
        else                                rdata = '0;
    end
endmodule

// File: rtl/i2c_ctrl_regs.sv
// Top of the I2C register front end: decodes the bus, holds control flags
// and status, drives the engine controls and the interrupt request.
// Assumes a single-cycle write strobe and synchronous active-low reset.
module i2c_ctrl_regs
    import i2c_regs_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int OFF_SET  = 'h00,
    parameter int OFF_STAT = 'h04,
    parameter int OFF_CLR  = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [4:0]        eng_code,
    input  logic              eng_enter,
    output logic              ctl_aa,
    output logic              ctl_sta,
    output logic              ctl_en,
    output logic              irq
);
    localparam int EN_POS = flag_pos(FLAG_EN);

    logic              set_we;
    logic              clr_we;
    logic [NFLAG-1:0]  flags;
    logic [CODE_W-1:0] code_q;
    logic              hw_si_set;
    logic              force_idle;
    logic              si_q;

    assign set_we = bus_wr && (bus_addr == ADDR_W'(OFF_SET));
    assign clr_we = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));

    i2c_flag_bank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_we     (set_we),
        .clr_we     (clr_we),
        .wdata      (bus_wdata),
        .hw_si_set  (hw_si_set),
        .force_idle (force_idle),
        .flags      (flags)
    );

    i2c_status_track u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_q        (flags[FLAG_EN]),
        .eng_enter   (eng_enter),
        .eng_code    (eng_code),
        .disable_req (clr_we && bus_wdata[EN_POS]),
        .code_q      (code_q),
        .hw_si_set   (hw_si_set),
        .force_idle  (force_idle)
    );

    i2c_read_mux #(
        .ADDR_W   (ADDR_W),
        .OFF_SET  (OFF_SET),
        .OFF_STAT (OFF_STAT)
    ) u_rd (
        .addr   (bus_addr),
        .flags  (flags),
        .code_q (code_q),
        .rdata  (bus_rdata)
    );

    assign si_q    = flags[FLAG_SI];
    assign ctl_aa  = flags[FLAG_AA];
    assign ctl_sta = flags[FLAG_STA];
    assign ctl_en  = flags[FLAG_EN];
    assign irq     = si_q && ctl_en;
endmodule

// File: rtl/i2c_ctrl_regs_chk.sv
// Assertion checker for i2c_ctrl_regs, attached by bind below.
module i2c_ctrl_regs_chk #(
    parameter int ADDR_W   = 5,
    parameter int OFF_SET  = 'h00,
    parameter int OFF_STAT = 'h04,
    parameter int OFF_CLR  = 'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [4:0]        eng_code,
    input logic              eng_enter,
    input logic              ctl_sta,
    input logic              ctl_en,
    input logic              irq,
    input logic              si_q,
    input logic [4:0]        code_q,
    input logic              force_idle
);
    logic clr_hit;
    assign clr_hit = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_SET)) |-> (bus_rdata[1:0] == 2'b00 && !bus_rdata[4] && !bus_rdata[7]));

    // R5
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_STAT)) |-> (bus_rdata[2:0] == 3'b000));

    // R9
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_en && si_q));

    // R6
    entry_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_enter && ctl_en && eng_code != 5'h1F && !(clr_hit && bus_wdata[6])) |=> irq);

    // R7
    race_keeps_si_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_enter && ctl_en && eng_code != 5'h1F && clr_hit && bus_wdata[3]) |=> si_q);

    // R8
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && bus_wdata[6]) |=> !ctl_en);

    // R8
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && bus_wdata[6] && ctl_en) |=> ##1 (code_q == 5'h1F && !si_q && !ctl_sta));

    // R3
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && bus_wdata == 8'h00 && !eng_enter && !force_idle) |=> $stable(ctl_en) && $stable(si_q) && $stable(ctl_sta));

    // R5
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_enter && !ctl_en && !force_idle) |=> $stable(code_q));
endmodule

bind i2c_ctrl_regs i2c_ctrl_regs_chk #(
    .ADDR_W   (ADDR_W),
    .OFF_SET  (OFF_SET),
    .OFF_STAT (OFF_STAT),
    .OFF_CLR  (OFF_CLR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_code   (eng_code),
    .eng_enter  (eng_enter),
    .ctl_sta    (ctl_sta),
    .ctl_en     (ctl_en),
    .irq        (irq),
    .si_q       (si_q),
    .code_q     (code_q),
    .force_idle (force_idle)
);

// File: tb/i2c_ctrl_regs_tb.sv
module i2c_ctrl_regs_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [4:0]    eng_code = 5'h1F;
    logic          eng_enter = 1'b0;
    logic          ctl_aa, ctl_sta, ctl_en, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_code(eng_code),
        .eng_enter(eng_enter), .ctl_aa(ctl_aa), .ctl_sta(ctl_sta),
        .ctl_en(ctl_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Bus write: drive at a falling edge, return at the next falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic eng(input logic [4:0] c);
        eng_code = c; eng_enter = 1'b1;
        @(negedge clk);
        eng_enter = 1'b0;
    endtask

    task automatic expect_regs(input string req, input logic [7:0] ctrl, input logic [7:0] stat);
        logic [7:0] v;
        rd(5'h00, v); chk(req, v, ctrl);
        rd(5'h04, v); chk(req, v, stat);
    endtask

    task automatic t_reset();
        expect_regs("R1", 8'h00, 8'hF8);
        chk("R1", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_set_clear();
        wr(5'h00, 8'h64);
        expect_regs("R2", 8'h64, 8'hF8);
        chk("R2", {5'd0, ctl_aa, ctl_sta, ctl_en}, 8'h07);
        wr(5'h00, 8'h00);
        expect_regs("R2", 8'h64, 8'hF8);
        wr(5'h18, 8'h20);
        expect_regs("R3", 8'h44, 8'hF8);
        wr(5'h18, 8'h00);
        expect_regs("R3", 8'h44, 8'hF8);
    endtask

    task automatic t_reserved();
        wr(5'h00, 8'h93);
        expect_regs("R4", 8'h44, 8'hF8);
        wr(5'h18, 8'h93);
        expect_regs("R4", 8'h44, 8'hF8);
    endtask

    task automatic t_status();
        eng(5'h01);
        expect_regs("R6", 8'h4C, 8'h08);
        chk("R9", {7'd0, irq}, 8'h01);
        wr(5'h18, 8'h08);
        expect_regs("R3", 8'h44, 8'h08);
        chk("R9", {7'd0, irq}, 8'h00);
        eng(5'h1F);
        expect_regs("R6", 8'h44, 8'hF8);
        eng(5'h0B);
        expect_regs("R5", 8'h4C, 8'h58);
    endtask

    task automatic t_race();
        wr(5'h18, 8'h08);
        expect_regs("R3", 8'h44, 8'h58);
        bus_addr = 5'h18; bus_wdata = 8'h08; bus_wr = 1'b1;
        eng_code = 5'h0C; eng_enter = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_enter = 1'b0;
        expect_regs("R7", 8'h4C, 8'h60);
    endtask

    task automatic t_disable();
        wr(5'h00, 8'h20);
        expect_regs("R8", 8'h6C, 8'h60);
        wr(5'h18, 8'h40);
        expect_regs("R8", 8'h2C, 8'h60);
        chk("R9", {7'd0, irq}, 8'h00);
        @(negedge clk);
        expect_regs("R8", 8'h04, 8'hF8);
    endtask

    task automatic t_disabled_ignore();
        eng(5'h02);
        expect_regs("R5", 8'h04, 8'hF8);
        wr(5'h00, 8'h08);
        expect_regs("R9", 8'h0C, 8'hF8);
        chk("R9", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_other_addr();
        logic [7:0] v;
        wr(5'h08, 8'hFF);
        wr(5'h1C, 8'hFF);
        expect_regs("R10", 8'h0C, 8'hF8);
        rd(5'h08, v); chk("R10", v, 8'h00);
        rd(5'h18, v); chk("R10", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_reserved();
        t_status();
        t_race();
        t_disable();
        t_disabled_ignore();
        t_other_addr();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule